// File: doc/BRIEF.md
# Prioritized Two-Output Interrupt Controller

This block collects up to 128 level-sensitive interrupt requests and presents them to a processor on two separate lines: a normal interrupt line and a fast interrupt line. Each source can be raised by its hardware input or by a software trigger bit. It can be masked, and it carries its own level setting that chooses a 6-bit priority and which of the two lines it is steered to. Sources are organised in banks of 32. Source n sits in bank n/32 at bit n%32.

Each line has its own priority sorter. When a line is free, its sorter picks the most urgent qualifying request, latches the source number and priority, and raises the line. The line and the reported winner stay frozen until software writes the agreement bit for that line. A global threshold can hold back requests whose priority is not urgent enough. Software reaches all of this through a single-cycle register port with a word address, a write strobe and 32-bit write and read data.

Register map (word addresses):
- 0x00: active normal-line winner.
- 0x01: active fast-line winner.
- 0x02: agreement control, write only.
- 0x03: active normal-line priority.
- 0x04: active fast-line priority.
- 0x05: threshold.
- 0x10 + 8*b: bank b. The offsets within a bank are:
  - +0 raw hardware inputs
  - +1 mask
  - +2 mask clear
  - +3 mask set
  - +4 software trigger set / read
  - +5 software trigger clear
  - +6 pending normal
  - +7 pending fast
- 0x80 + n: level register of source n.

Top module: `prio_intc`

## Requirements
- R1: After reset both lines are low. All mask bits read 1, every level register reads 0 and the threshold reads 0xFF. Addresses 0x00, 0x01, 0x03 and 0x04 read the spurious value 0xFFFFFF80.
- R2: A write to mask clear (bank offset +2) clears every mask bit written as 1. A write to mask set (offset +3) sets every mask bit written as 1. Bits written as 0 keep their value. The mask reads at offset +1.
- R3: A write to trigger set (offset +4) sets software trigger bits, and a write to trigger clear (offset +5) clears them, in both cases for bits written as 1. Offset +4 reads back the trigger bits. Each trigger bit is ORed with its hardware input to form the request, while offset +0 shows the hardware inputs only.
- R4: Pending normal (offset +6) reads request AND NOT mask AND NOT route. Pending fast (offset +7) reads request AND NOT mask AND route.
- R5: Level register 0x80+n holds route in bit 0 (0 = normal line, 1 = fast line) and priority in bits 7:2. It reads back only those fields; all other bits read 0.
- R6: Among qualifying pending sources of a line, the smallest priority number wins. On a tie, the smaller source number wins.
- R7: Once a line is raised, the line stays high and its winner and priority registers stay unchanged until the agreement bit for that line is written. The agreement bit is bit 0 of address 0x02 for the normal line and bit 1 for the fast line. Writing one line's bit leaves the other line alone.
- R8: On the clock edge that takes an agreement write, the line drops. A fresh sort may raise it again on the next edge.
- R9: When the threshold is not 0xFF, only sources whose priority is numerically below the threshold qualify. A threshold of 0 therefore blocks every source.
- R10: While a line is free and no source qualifies, the line stays low and its winner and priority registers read 0xFFFFFF80. Otherwise the winner reads the source number in bits 6:0 and the priority reads the level in bits 5:0.
- R11: Reads of unmapped addresses, of the control address, and of banks or sources beyond the configured count return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level-sensitive hardware requests |
| addr_i | input | 8 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The assertions check on every cycle that a raised line and its latched winner and priority stay frozen until the line's own agreement bit arrives. They also check that an agreement write drops the line on the next edge, and that a line only rises for a priority below the threshold that was in force. The bench scenarios cover the rest: that the smallest priority, and then the smallest source number, actually wins; the set and clear semantics of the mask and trigger aliases; the field positions of the level registers; the pending views; and the spurious readings. These depend on register contents that only a sequence of writes and reads can set up and observe.

// File: rtl/prio_intc.sv
`timescale 1ns/1ps
module prio_intc #(
  parameter int NUM_SRC = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [7:0]         addr_i,
  input  logic               we_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int BANKS = NUM_SRC / 32;
  localparam logic [7:0] A_AIRQ = 8'h00, A_AFIQ = 8'h01, A_CTRL = 8'h02,
                         A_PIRQ = 8'h03, A_PFIQ = 8'h04, A_THR = 8'h05,
                         A_BANK = 8'h10, A_LVL = 8'h80;
  localparam logic [31:0] SPUR = 32'hFFFF_FF80;

  logic [NUM_SRC-1:0] mask_q, sw_q, route_q;
  logic [5:0]         prio_q [NUM_SRC];
  logic [7:0]         thr_q;

  logic [NUM_SRC-1:0] req, pend_irq, pend_fiq;
  assign req      = src_i | sw_q;
  assign pend_irq = req & ~mask_q & ~route_q;
  assign pend_fiq = req & ~mask_q & route_q;

  logic       bank_hit, lvl_hit, ctrl_wr;
  logic [1:0] bk;
  logic [6:0] base, idx;
  logic [8:0] boff;
  assign boff     = {1'b0, addr_i} - {1'b0, A_BANK};
  assign bk       = boff[4:3];
  assign base     = {bk, 5'b0};
  assign bank_hit = addr_i >= A_BANK && addr_i < 8'(16 + 8 * BANKS);
  assign idx      = addr_i[6:0];
  assign lvl_hit  = addr_i[7] && ({1'b0, idx} < 8'(NUM_SRC));
  assign ctrl_wr  = we_i && addr_i == A_CTRL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      sw_q    <= '0;
      route_q <= '0;
      thr_q   <= 8'hFF;
      for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
    end else if (we_i) begin
      if (addr_i == A_THR) thr_q <= wdata_i[7:0];
      if (bank_hit) begin
        case (addr_i[2:0])
          3'd2: mask_q[base +: 32] <= mask_q[base +: 32] & ~wdata_i;
          3'd3: mask_q[base +: 32] <= mask_q[base +: 32] | wdata_i;
          3'd4: sw_q[base +: 32]   <= sw_q[base +: 32] | wdata_i;
          3'd5: sw_q[base +: 32]   <= sw_q[base +: 32] & ~wdata_i;
          default: ;
        endcase
      end
      if (lvl_hit) begin
        route_q[idx] <= wdata_i[0];
        prio_q[idx]  <= wdata_i[7:2];
      end
    end
  end

  function automatic logic [13:0] pick(input logic [NUM_SRC-1:0] p);
    logic       hit;
    logic [6:0] n;
    logic [5:0] b;
    hit = 1'b0; n = '0; b = '1;
    for (int i = 0; i < NUM_SRC; i++)
      if (p[i] && (thr_q == 8'hFF || {2'b0, prio_q[i]} < thr_q) &&
          (!hit || prio_q[i] < b)) begin
        hit = 1'b1; n = 7'(i); b = prio_q[i];
      end
    return {hit, n, b};
  endfunction

  logic [13:0] best [2];
  assign best[0] = pick(pend_irq);
  assign best[1] = pick(pend_fiq);

  logic       busy_q [2];
  logic       spur_q [2];
  logic [6:0] num_q  [2];
  logic [5:0] lvl_q  [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        busy_q[c] <= 1'b0; spur_q[c] <= 1'b1; num_q[c] <= '0; lvl_q[c] <= '0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (busy_q[c]) begin
          if (ctrl_wr && wdata_i[c]) busy_q[c] <= 1'b0;
        end else begin
          busy_q[c] <= best[c][13];
          spur_q[c] <= !best[c][13];
          num_q[c]  <= best[c][12:6];
          lvl_q[c]  <= best[c][5:0];
        end
      end
    end
  end

  assign irq_o = busy_q[0];
  assign fiq_o = busy_q[1];

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_AIRQ)      rdata_o = spur_q[0] ? SPUR : {25'b0, num_q[0]};
    else if (addr_i == A_AFIQ) rdata_o = spur_q[1] ? SPUR : {25'b0, num_q[1]};
    else if (addr_i == A_PIRQ) rdata_o = spur_q[0] ? SPUR : {26'b0, lvl_q[0]};
    else if (addr_i == A_PFIQ) rdata_o = spur_q[1] ? SPUR : {26'b0, lvl_q[1]};
    else if (addr_i == A_THR)  rdata_o = {24'b0, thr_q};
    else if (bank_hit) begin
      case (addr_i[2:0])
        3'd0: rdata_o = src_i[base +: 32];
        3'd1: rdata_o = mask_q[base +: 32];
        3'd4: rdata_o = sw_q[base +: 32];
        3'd6: rdata_o = pend_irq[base +: 32];
        3'd7: rdata_o = pend_fiq[base +: 32];
        default: rdata_o = '0;
      endcase
    end else if (lvl_hit) rdata_o = {24'b0, prio_q[idx], 1'b0, route_q[idx]};
  end

  // R7: a raised line and its winner hold until the agreement bit
  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !(ctrl_wr && wdata_i[0]) |=> irq_o && $stable(num_q[0]) && $stable(lvl_q[0]));
  a_r7_fiq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o && !(ctrl_wr && wdata_i[1]) |=> fiq_o && $stable(num_q[1]) && $stable(lvl_q[1]));
  // R8: agreement drops the line
  a_r8_irq_gap: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && ctrl_wr && wdata_i[0] |=> !irq_o);
  a_r8_fiq_gap: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o && ctrl_wr && wdata_i[1] |=> !fiq_o);
  // R9: a line only rises for a priority under the threshold in force
  a_r9_irq_thr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(thr_q) == 8'hFF || {2'b0, lvl_q[0]} < $past(thr_q)));
  a_r9_fiq_thr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> ($past(thr_q) == 8'hFF || {2'b0, lvl_q[1]} < $past(thr_q)));
endmodule

// File: tb/tb_prio_intc.sv
`timescale 1ns/1ps
module tb_prio_intc;
  logic         clk = 0, rst_n = 0, we = 0;
  logic [127:0] src = '0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0, rdata;
  logic         irq, fiq;
  int ntot = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_intc dut (.clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .we_i(we),
                 .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq));

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  event mon_ev;

  always @(mon_ev) begin
    item_t it;
    logic [31:0] act;
    it  = q.pop_front();
    act = it.kind == 0 ? rdata : it.kind == 1 ? {31'b0, irq} : {31'b0, fiq};
    ntot++;
    if (act !== it.exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic reset_dut();
    @(negedge clk); rst_n = 0; src = '0; we = 0;
    repeat (3) @(negedge clk); rst_n = 1;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask
  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); addr = a; we = 0;
    q.push_back('{0, e, t}); #0.1 -> mon_ev; #0.1;
  endtask
  task automatic exp_pin(input int k, input logic e, input string t);
    q.push_back('{k, {31'b0, e}, t}); #0.1 -> mon_ev; #0.1;
  endtask

  initial begin
    reset_dut();
    exp_pin(1, 0, "R1 irq low");
    exp_pin(2, 0, "R1 fiq low");
    exp_rd(8'h00, 32'hFFFF_FF80, "R1 R10 irq winner spurious");
    exp_rd(8'h01, 32'hFFFF_FF80, "R1 R10 fiq winner spurious");
    exp_rd(8'h03, 32'hFFFF_FF80, "R1 irq prio spurious");
    exp_rd(8'h04, 32'hFFFF_FF80, "R1 fiq prio spurious");
    exp_rd(8'h05, 32'h0000_00FF, "R1 threshold");
    exp_rd(8'h11, 32'hFFFF_FFFF, "R1 mask bank0");
    exp_rd(8'h85, 32'h0, "R1 level 5");
    exp_rd(8'h06, 32'h0, "R11 unmapped");
    exp_rd(8'h02, 32'h0, "R11 control read");
    exp_rd(8'h30, 32'h0, "R11 beyond banks");

    reset_dut();
    wr(8'h12, 32'hF0);
    exp_rd(8'h11, 32'hFFFF_FF0F, "R2 mask clear");
    wr(8'h13, 32'h0); wr(8'h12, 32'h0);
    exp_rd(8'h11, 32'hFFFF_FF0F, "R2 zero writes ignored");
    wr(8'h13, 32'h10);
    exp_rd(8'h11, 32'hFFFF_FF1F, "R2 mask set");
    exp_rd(8'h29, 32'hFFFF_FFFF, "R2 other bank untouched");

    wr(8'h85, 32'hFD);
    exp_rd(8'h85, 32'hFD, "R5 level fields");
    wr(8'h85, 32'hFFFF_FF02);
    exp_rd(8'h85, 32'h0, "R5 other bits dropped");
    wr(8'hFF, 32'h04);
    exp_rd(8'hFF, 32'h04, "R5 last source");

    reset_dut();
    src[5] = 1; src[6] = 1;
    wr(8'h86, 32'h01);
    exp_rd(8'h10, 32'h60, "R3 raw inputs");
    exp_rd(8'h16, 32'h0, "R4 masked pending");
    wr(8'h12, 32'h60);
    exp_rd(8'h16, 32'h20, "R4 pending normal");
    exp_rd(8'h17, 32'h40, "R4 pending fast");
    wr(8'h14, 32'h200);
    exp_rd(8'h14, 32'h200, "R3 trigger set");
    exp_rd(8'h16, 32'h20, "R3 trigger masked");
    wr(8'h12, 32'h200);
    exp_rd(8'h16, 32'h220, "R3 trigger ORed");
    exp_rd(8'h10, 32'h60, "R3 raw excludes trigger");
    wr(8'h15, 32'h200);
    exp_rd(8'h14, 32'h0, "R3 trigger clear");
    exp_rd(8'h16, 32'h20, "R3 pending after clear");
    exp_rd(8'h00, 32'd5, "R6 irq winner");
    exp_rd(8'h01, 32'd6, "R4 fiq winner");
    exp_pin(2, 1, "R4 fiq raised");
    wr(8'h02, 32'h2);
    exp_pin(2, 0, "R8 fiq drops");
    exp_pin(1, 1, "R7 irq unaffected");
    tick();
    exp_pin(2, 1, "R8 fiq re-raised");

    reset_dut();
    wr(8'h83, 32'h28); wr(8'hA8, 32'h10); wr(8'hC6 - 8'h00, 32'h10); wr(8'hE4, 32'h50);
    wr(8'h12, 32'hFFFF_FFFF); wr(8'h1A, 32'hFFFF_FFFF);
    wr(8'h22, 32'hFFFF_FFFF); wr(8'h2A, 32'hFFFF_FFFF);
    @(negedge clk); src[3] = 1; src[40] = 1; src[70] = 1; src[100] = 1;
    tick(); tick();
    exp_rd(8'h00, 32'd40, "R6 lowest prio then lowest number");
    exp_rd(8'h03, 32'd4, "R6 winner priority");
    exp_rd(8'h01, 32'hFFFF_FF80, "R10 fiq none qualifies");
    @(negedge clk); src[40] = 0; src[2] = 1;
    tick();
    exp_rd(8'h00, 32'd40, "R7 winner frozen");
    exp_pin(1, 1, "R7 irq held");
    wr(8'h02, 32'h2); tick();
    exp_rd(8'h00, 32'd40, "R7 fast agreement ignored by normal");
    wr(8'h02, 32'h1);
    exp_pin(1, 0, "R8 irq drops");
    tick();
    exp_pin(1, 1, "R8 irq re-raised");
    exp_rd(8'h00, 32'd2, "R8 new winner");
    exp_rd(8'h03, 32'd0, "R8 new priority");

    reset_dut();
    wr(8'h88, 32'h14);
    @(negedge clk); src[8] = 1;
    wr(8'h05, 32'h05); wr(8'h12, 32'h100);
    tick(); tick();
    exp_pin(1, 0, "R9 blocked at threshold");
    exp_rd(8'h00, 32'hFFFF_FF80, "R9 R10 spurious winner");
    exp_rd(8'h03, 32'hFFFF_FF80, "R10 spurious priority");
    wr(8'h05, 32'h06); tick();
    exp_pin(1, 1, "R9 passes below threshold");
    exp_rd(8'h00, 32'd8, "R9 winner");
    exp_rd(8'h03, 32'd5, "R9 priority");
    exp_rd(8'h05, 32'h06, "R9 threshold readback");

    done = 1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      ntot++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end
endmodule